// File: doc/BRIEF.md
# Transmit Descriptor Process Controller

This block steps a transmit engine through a circular list of descriptors. Each descriptor holds an ownership flag, a frame length and two write-back marks, and it lives in a small on-chip register file. Software fills descriptors through a write port and inspects them through a registered read port. It starts and stops the engine with one-cycle command strobes and wakes a suspended engine with a poll-demand strobe.

For each descriptor the engine owns, the block sends the frame as a byte stream on a valid/ready port. It then hands the descriptor back to the host, setting a completion mark, and moves on to the next list entry. If it meets a descriptor that the host still owns, it suspends. A jabber watchdog aborts a frame that keeps the output busy for too long. Every stop or suspend cause, and every finished frame, raises its own sticky status flag, which software clears by writing one.

Top module: `tx_desc_sequencer`

## Requirements
- R1: After reset, `proc_state` is 0, `sts` is 0 and `tx_valid` is low. The list pointer starts at entry 0.
- R2: `proc_state` encodes the process as 0 = stopped, 1 = fetching, 2 = transferring, 3 = suspended. A `cmd_start` strobe while stopped moves it to 1. A fetch takes two cycles, then it goes to 2 or 3.
- R3: For an engine-owned descriptor (own = 1) with length field L, the block sends L+1 bytes. Byte k carries the value k, and `tx_last` marks the final byte. While `tx_ready` is low, the data and last flag hold.
- R4: When the last byte is accepted, `sts[0]` (frame done) is set. The descriptor is written back with own = 0, done mark = 1, jabber mark = 0 and L unchanged. The pointer advances and wraps from NUM_DESC-1 to 0.
- R5: A fetched descriptor with own = 0 sends no bytes. The process enters state 3 and sets `sts[2]` (buffer unavailable).
- R6: A suspended process leaves state 3 only on `cmd_poll` or `cmd_stop`. A poll starts a new fetch that reads the ownership flag again. A poll in any other state has no effect.
- R7: If `tx_valid` stays high for JAB_LIMIT cycles of one frame without the last byte being accepted, the frame is aborted. `tx_valid` drops, the process goes to 0, and `sts[3]` (jabber) and `sts[1]` are set. The descriptor is written back with own = 0, jabber mark = 1 and done mark = 0, and the pointer does not advance.
- R8: `cmd_stop` takes a fetching or suspended process to 0 on the next cycle. During a transfer, the current frame finishes first and then the process goes to 0. Every entry into state 0 after reset sets `sts[1]` (stopped). `cmd_start` has no effect unless the process is stopped.
- R9: Status flags stay set until a one is written to the matching bit of `sts_clr`. Bits written with zero keep their value, and a flag being set in the same cycle wins over its clear.
- R10: The software read port returns the own, jabber, done and length fields of entry `sw_raddr` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Start strobe |
| cmd_stop | input | 1 | Stop strobe |
| cmd_poll | input | 1 | Poll-demand strobe |
| sts_clr | input | 4 | Write-one-to-clear mask for `sts` |
| sw_we | input | 1 | Descriptor write enable |
| sw_waddr | input | AW | Descriptor write index |
| sw_wown | input | 1 | Ownership flag to write (1 = engine) |
| sw_wlen | input | LEN_W | Length field to write (bytes minus one) |
| sw_raddr | input | AW | Descriptor read index |
| sw_rown | output | 1 | Read ownership flag |
| sw_rjab | output | 1 | Read jabber mark |
| sw_rdone | output | 1 | Read done mark |
| sw_rlen | output | LEN_W | Read length field |
| tx_ready | input | 1 | Downstream accepts a byte |
| tx_valid | output | 1 | Byte present |
| tx_data | output | DATA_W | Byte value |
| tx_last | output | 1 | Final byte of the frame |
| proc_state | output | 3 | Process state code |
| sts | output | 4 | Sticky flags: 0 done, 1 stopped, 2 buffer unavailable, 3 jabber |

## Verification
A wrong process state shows on `proc_state` in the very next cycle. It also shows within two cycles as a missing or extra byte on the transmit port, or as a status flag raised at the wrong moment. A wrong pointer or write-back only shows when that entry is fetched again: an unexpected suspend, or a frame with the wrong length. It also shows when software reads the entry back. Because of this, the bench runs the list past a wrap and reads descriptors back after completion and after a jabber abort.

// File: rtl/txd_pkg.sv
package txd_pkg;
  typedef enum logic [2:0] {
    PS_STOP  = 3'd0,
    PS_FETCH = 3'd1,
    PS_XFER  = 3'd2,
    PS_SUSP  = 3'd3
  } proc_state_t;

  localparam int NSTS    = 4;
  localparam int ST_DONE = 0;
  localparam int ST_STOP = 1;
  localparam int ST_BUFU = 2;
  localparam int ST_JAB  = 3;
endpackage

// File: rtl/txd_desc_ram.sv
module txd_desc_ram #(
  parameter int DEPTH = 4,
  parameter int LEN_W = 8,
  parameter int AW    = 2,
  localparam int DW   = LEN_W + 3
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [DW-1:0]    wdata,
  input  logic [AW-1:0]    raddr_e,
  output logic [LEN_W:0]   rdata_e,
  input  logic [AW-1:0]    raddr_s,
  output logic [DW-1:0]    rdata_s
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // engine port: ownership flag and length only
  always_ff @(posedge clk) begin
    rdata_e <= {mem[raddr_e][DW-1], mem[raddr_e][LEN_W-1:0]};
  end

  always_ff @(posedge clk) begin
    rdata_s <= mem[raddr_s];
  end
endmodule

// File: rtl/txd_jabber.sv
module txd_jabber #(
  parameter int LIMIT = 24,
  localparam int CW   = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic active,
  output logic expire
);
  logic [CW-1:0] cnt;

  assign expire = active && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (active)    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/txd_status.sv
module txd_status #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= (flags & ~clr) | set;
  end
endmodule

// File: rtl/tx_desc_sequencer.sv
module tx_desc_sequencer #(
  parameter int NUM_DESC  = 4,
  parameter int LEN_W     = 8,
  parameter int DATA_W    = 8,
  parameter int JAB_LIMIT = 24,
  localparam int AW       = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_start,
  input  logic              cmd_stop,
  input  logic              cmd_poll,
  input  logic [3:0]        sts_clr,
  input  logic              sw_we,
  input  logic [AW-1:0]     sw_waddr,
  input  logic              sw_wown,
  input  logic [LEN_W-1:0]  sw_wlen,
  input  logic [AW-1:0]     sw_raddr,
  output logic              sw_rown,
  output logic              sw_rjab,
  output logic              sw_rdone,
  output logic [LEN_W-1:0]  sw_rlen,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_last,
  output logic [2:0]        proc_state,
  output logic [3:0]        sts
);
  import txd_pkg::*;

  localparam int DW = LEN_W + 3;

  proc_state_t      state;
  logic             fphase;
  logic [AW-1:0]    ptr;
  logic [LEN_W-1:0] bcnt;
  logic [LEN_W-1:0] blen;
  logic             stop_pend;

  logic [LEN_W:0]   rd_e;
  logic [DW-1:0]    rd_s;
  logic             own_ok;
  logic [LEN_W-1:0] len_rd;
  logic             jab_exp;
  logic             hs, fin, go_xfer, stop_req;
  logic [LEN_W-1:0] nbcnt;
  logic [AW-1:0]    ptr_nxt;

  logic             eng_we;
  logic [DW-1:0]    eng_wdata;
  logic             ram_we;
  logic [AW-1:0]    ram_waddr;
  logic [DW-1:0]    ram_wdata;
  logic [NSTS-1:0]  sts_set;

  assign own_ok   = rd_e[LEN_W];
  assign len_rd   = rd_e[LEN_W-1:0];
  assign hs       = tx_valid && tx_ready;
  assign fin      = hs && tx_last;
  assign nbcnt    = bcnt + 1'b1;
  assign stop_req = stop_pend || cmd_stop;
  assign ptr_nxt  = (ptr == AW'(NUM_DESC - 1)) ? '0 : ptr + 1'b1;
  assign go_xfer  = (state == PS_FETCH) && !cmd_stop && fphase && own_ok;

  // write-back and status set conditions
  always_comb begin
    eng_we    = 1'b0;
    eng_wdata = '0;
    sts_set   = '0;
    case (state)
      PS_FETCH: begin
        if (cmd_stop)                   sts_set[ST_STOP] = 1'b1;
        else if (fphase && !own_ok)     sts_set[ST_BUFU] = 1'b1;
      end
      PS_XFER: begin
        if (fin) begin
          eng_we            = 1'b1;
          eng_wdata         = {1'b0, 1'b0, 1'b1, blen};
          sts_set[ST_DONE]  = 1'b1;
          sts_set[ST_STOP]  = stop_req;
        end else if (jab_exp) begin
          eng_we            = 1'b1;
          eng_wdata         = {1'b0, 1'b1, 1'b0, blen};
          sts_set[ST_JAB]   = 1'b1;
          sts_set[ST_STOP]  = 1'b1;
        end
      end
      PS_SUSP: begin
        if (cmd_stop) sts_set[ST_STOP] = 1'b1;
      end
      default: ;
    endcase
  end

  // engine write-back takes the single write port ahead of software
  assign ram_we    = eng_we || sw_we;
  assign ram_waddr = eng_we ? ptr : sw_waddr;
  assign ram_wdata = eng_we ? eng_wdata : {sw_wown, 2'b00, sw_wlen};

  txd_desc_ram #(.DEPTH(NUM_DESC), .LEN_W(LEN_W), .AW(AW)) u_ram (
    .clk     (clk),
    .we      (ram_we),
    .waddr   (ram_waddr),
    .wdata   (ram_wdata),
    .raddr_e (ptr),
    .rdata_e (rd_e),
    .raddr_s (sw_raddr),
    .rdata_s (rd_s)
  );

  txd_jabber #(.LIMIT(JAB_LIMIT)) u_jab (
    .clk     (clk),
    .rst     (rst),
    .restart (go_xfer),
    .active  (tx_valid),
    .expire  (jab_exp)
  );

  txd_status #(.N(NSTS)) u_sts (
    .clk   (clk),
    .rst   (rst),
    .set   (sts_set),
    .clr   (sts_clr),
    .flags (sts)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= PS_STOP;
      fphase    <= 1'b0;
      ptr       <= '0;
      bcnt      <= '0;
      blen      <= '0;
      stop_pend <= 1'b0;
      tx_valid  <= 1'b0;
      tx_data   <= '0;
      tx_last   <= 1'b0;
    end else begin
      case (state)
        PS_STOP: begin
          stop_pend <= 1'b0;
          if (cmd_start) begin
            state  <= PS_FETCH;
            fphase <= 1'b0;
          end
        end
        PS_FETCH: begin
          if (cmd_stop) begin
            state <= PS_STOP;
          end else if (!fphase) begin
            fphase <= 1'b1;
          end else if (own_ok) begin
            state    <= PS_XFER;
            tx_valid <= 1'b1;
            tx_data  <= '0;
            tx_last  <= (len_rd == '0);
            bcnt     <= '0;
            blen     <= len_rd;
          end else begin
            state <= PS_SUSP;
          end
        end
        PS_XFER: begin
          if (cmd_stop) stop_pend <= 1'b1;
          if (fin) begin
            tx_valid <= 1'b0;
            tx_last  <= 1'b0;
            ptr      <= ptr_nxt;
            if (stop_req) begin
              state     <= PS_STOP;
              stop_pend <= 1'b0;
            end else begin
              state  <= PS_FETCH;
              fphase <= 1'b0;
            end
          end else if (jab_exp) begin
            tx_valid  <= 1'b0;
            tx_last   <= 1'b0;
            state     <= PS_STOP;
            stop_pend <= 1'b0;
          end else if (hs) begin
            bcnt    <= nbcnt;
            tx_data <= DATA_W'(nbcnt);
            tx_last <= (nbcnt == blen);
          end
        end
        PS_SUSP: begin
          if (cmd_stop) begin
            state <= PS_STOP;
          end else if (cmd_poll) begin
            state  <= PS_FETCH;
            fphase <= 1'b0;
          end
        end
        default: state <= PS_STOP;
      endcase
    end
  end

  assign proc_state = state;
  assign sw_rown    = rd_s[DW-1];
  assign sw_rjab    = rd_s[DW-2];
  assign sw_rdone   = rd_s[DW-3];
  assign sw_rlen    = rd_s[LEN_W-1:0];
endmodule

// File: rtl/tx_desc_sequencer_chk.sv
module tx_desc_sequencer_chk #(
  parameter int DATA_W    = 8,
  parameter int JAB_LIMIT = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_stop,
  input logic              cmd_poll,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              tx_last,
  input logic [DATA_W-1:0] tx_data,
  input logic [2:0]        proc_state,
  input logic [3:0]        sts
);
  int vcnt;

  always_ff @(posedge clk) begin
    if (rst) vcnt <= 0;
    else     vcnt <= (tx_valid && !(tx_ready && tx_last)) ? vcnt + 1 : 0;
  end

  p_state_code_r2: assert property (@(posedge clk) disable iff (rst)
    proc_state <= 3'd3);

  p_valid_in_xfer_r3: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> proc_state == 3'd2);

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=>
      ((tx_valid && $stable(tx_data) && $stable(tx_last)) || proc_state == 3'd0));

  p_done_flag_r4: assert property (@(posedge clk) disable iff (rst)
    $past(tx_valid && tx_ready && tx_last) |-> sts[0]);

  p_susp_flag_r5: assert property (@(posedge clk) disable iff (rst)
    (proc_state == 3'd3 && $past(proc_state) != 3'd3) |-> sts[2]);

  p_resume_cause_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(proc_state) == 3'd3 && proc_state != 3'd3) |-> ($past(cmd_poll) || $past(cmd_stop)));

  p_jabber_bound_r7: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> vcnt < JAB_LIMIT);

  p_stop_flag_r8: assert property (@(posedge clk) disable iff (rst)
    (proc_state == 3'd0 && $past(proc_state) != 3'd0) |-> sts[1]);
endmodule

bind tx_desc_sequencer tx_desc_sequencer_chk #(
  .DATA_W(DATA_W), .JAB_LIMIT(JAB_LIMIT)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cmd_stop   (cmd_stop),
  .cmd_poll   (cmd_poll),
  .tx_valid   (tx_valid),
  .tx_ready   (tx_ready),
  .tx_last    (tx_last),
  .tx_data    (tx_data),
  .proc_state (proc_state),
  .sts        (sts)
);

// File: tb/tx_desc_sequencer_test.sv
`timescale 1ns/1ps
module tx_desc_sequencer_test;
  localparam int N  = 4;
  localparam int LW = 8;
  localparam int DW = 8;
  localparam int JL = 24;
  localparam int AW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_start = 0, cmd_stop = 0, cmd_poll = 0;
  logic [3:0] sts_clr = 0;
  logic sw_we = 0;
  logic [AW-1:0] sw_waddr = 0, sw_raddr = 0;
  logic sw_wown = 0;
  logic [LW-1:0] sw_wlen = 0;
  logic sw_rown, sw_rjab, sw_rdone;
  logic [LW-1:0] sw_rlen;
  logic tx_ready = 1'b1;
  logic tx_valid, tx_last;
  logic [DW-1:0] tx_data;
  logic [2:0] proc_state;
  logic [3:0] sts;

  always #2.5 clk = ~clk;

  tx_desc_sequencer #(.NUM_DESC(N), .LEN_W(LW), .DATA_W(DW), .JAB_LIMIT(JL)) uut (
    .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cmd_poll(cmd_poll),
    .sts_clr(sts_clr), .sw_we(sw_we), .sw_waddr(sw_waddr), .sw_wown(sw_wown), .sw_wlen(sw_wlen),
    .sw_raddr(sw_raddr), .sw_rown(sw_rown), .sw_rjab(sw_rjab), .sw_rdone(sw_rdone), .sw_rlen(sw_rlen),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
    .proc_state(proc_state), .sts(sts));

  int checks = 0, failures = 0;
  string cur_req = "R1";
  int ready_mode = 0;
  int hs_cnt = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_state, m_fph, m_ptr, m_bcnt, m_blen, m_pend, m_jc, m_data;
  bit m_valid, m_last;
  bit [3:0] m_sts, m_set;
  int mown[N], mjab[N], mdone[N], mlen[N];
  bit m_ewr, m_sreq;

  always @(posedge clk) begin
    if (rst) begin
      m_state = 0; m_fph = 0; m_ptr = 0; m_bcnt = 0; m_blen = 0; m_pend = 0; m_jc = 0;
      m_data = 0; m_valid = 0; m_last = 0; m_sts = 0;
    end else begin
      m_set = 0; m_ewr = 0;
      case (m_state)
        0: begin
          m_pend = 0;
          if (cmd_start) begin m_state = 1; m_fph = 0; end
        end
        1: begin
          if (cmd_stop) begin m_state = 0; m_set[1] = 1; end
          else if (m_fph == 0) m_fph = 1;
          else if (mown[m_ptr] != 0) begin
            m_state = 2; m_valid = 1; m_data = 0; m_bcnt = 0;
            m_blen = mlen[m_ptr]; m_last = (m_blen == 0); m_jc = 0;
          end else begin m_state = 3; m_set[2] = 1; end
        end
        2: begin
          m_sreq = (m_pend != 0) || cmd_stop;
          if (cmd_stop) m_pend = 1;
          if (m_valid && tx_ready && m_last) begin
            mown[m_ptr] = 0; mjab[m_ptr] = 0; mdone[m_ptr] = 1; m_ewr = 1;
            m_set[0] = 1; m_valid = 0; m_last = 0;
            m_ptr = (m_ptr + 1) % N;
            if (m_sreq) begin m_state = 0; m_set[1] = 1; m_pend = 0; end
            else begin m_state = 1; m_fph = 0; end
          end else if (m_jc == JL - 1) begin
            mown[m_ptr] = 0; mjab[m_ptr] = 1; mdone[m_ptr] = 0; m_ewr = 1;
            m_set[3] = 1; m_set[1] = 1; m_valid = 0; m_last = 0; m_state = 0; m_pend = 0;
          end else begin
            m_jc++;
            if (tx_ready) begin
              m_bcnt++; m_data = m_bcnt % 256; m_last = (m_bcnt == m_blen);
            end
          end
        end
        3: begin
          if (cmd_stop) begin m_state = 0; m_set[1] = 1; end
          else if (cmd_poll) begin m_state = 1; m_fph = 0; end
        end
        default: ;
      endcase
      if (sw_we && !m_ewr) begin
        mown[sw_waddr] = sw_wown; mjab[sw_waddr] = 0; mdone[sw_waddr] = 0; mlen[sw_waddr] = sw_wlen;
      end
      m_sts = (m_sts & ~sts_clr) | m_set;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk({cur_req, " state"}, proc_state, m_state);
      chk({cur_req, " sts"}, sts, m_sts);
      chk({cur_req, " valid"}, tx_valid, m_valid);
      if (m_valid) begin
        chk({cur_req, " data"}, tx_data, m_data);
        chk({cur_req, " last"}, tx_last, m_last);
      end
    end
  end

  // ready pattern and handshake counting in one process
  initial begin
    int cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      tx_ready = (ready_mode == 0) ? 1'b1 : (ready_mode == 1) ? cyc[0] : 1'b0;
      if (tx_valid && tx_ready) hs_cnt++;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic do_start(); @(negedge clk) cmd_start = 1; @(negedge clk) cmd_start = 0; endtask
  task automatic do_stop();  @(negedge clk) cmd_stop  = 1; @(negedge clk) cmd_stop  = 0; endtask
  task automatic do_poll();  @(negedge clk) cmd_poll  = 1; @(negedge clk) cmd_poll  = 0; endtask
  task automatic do_clr(logic [3:0] v); @(negedge clk) sts_clr = v; @(negedge clk) sts_clr = 0; endtask
  task automatic wr_desc(int a, bit own, int len);
    @(negedge clk); sw_we = 1; sw_waddr = a[AW-1:0]; sw_wown = own; sw_wlen = len[LW-1:0];
    @(negedge clk); sw_we = 0;
  endtask
  task automatic rd_desc(int a);
    @(negedge clk); sw_raddr = a[AW-1:0];
    @(negedge clk);
  endtask
  task automatic wait_state(string tag, int s, int maxc);
    int k = 0;
    while (proc_state != s[2:0] && k < maxc) begin @(negedge clk); k++; end
    chk({tag, " reach state"}, proc_state, s);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    cur_req = "R1";
    chk("R1 state", proc_state, 0);
    chk("R1 sts", sts, 0);
    chk("R1 valid", tx_valid, 0);

    wr_desc(0, 1, 3);
    wr_desc(1, 1, 0);
    wr_desc(2, 0, 2);
    wr_desc(3, 0, 1);

    cur_req = "R6";
    do_poll();
    tick(2);
    chk("R6 poll while stopped", proc_state, 0);

    cur_req = "R3";
    ready_mode = 1;
    hs_cnt = 0;
    do_start();
    chk("R2 fetch after start", proc_state, 1);
    wait_state("R5", 3, 100);
    chk("R3 bytes for two frames", hs_cnt, 5);
    chk("R5 status done+bufu", sts, 4'b0101);
    rd_desc(0);
    chk("R4 d0 own", sw_rown, 0);
    chk("R4 d0 done", sw_rdone, 1);
    chk("R10 d0 len", sw_rlen, 3);

    cur_req = "R9";
    do_clr(4'b0100);
    chk("R9 clear bufu only", sts, 4'b0001);

    cur_req = "R6";
    hs_cnt = 0;
    do_poll();
    tick(4);
    chk("R6 reread host-owned", proc_state, 3);
    chk("R6 no bytes", hs_cnt, 0);
    chk("R6 bufu again", sts[2], 1);

    cur_req = "R4";
    ready_mode = 0;
    wr_desc(2, 1, 2);
    wr_desc(3, 1, 1);
    do_poll();
    wait_state("R4", 3, 100);
    chk("R4 bytes d2+d3", hs_cnt, 5);
    wr_desc(0, 1, 0);
    hs_cnt = 0;
    do_poll();
    wait_state("R4", 3, 100);
    chk("R4 wrap sends d0", hs_cnt, 1);
    rd_desc(3);
    chk("R4 d3 done", sw_rdone, 1);

    cur_req = "R8";
    do_start();
    tick(1);
    chk("R8 start ignored suspended", proc_state, 3);
    do_stop();
    chk("R8 stop from suspend", proc_state, 0);
    chk("R8 stopped flag", sts[1], 1);
    do_clr(4'b1111);
    chk("R9 clear all", sts, 0);

    wr_desc(1, 1, 5);
    hs_cnt = 0;
    do_start();
    wait_state("R8", 2, 20);
    do_stop();
    chk("R8 frame continues", proc_state, 2);
    wait_state("R8", 0, 40);
    chk("R8 whole frame sent", hs_cnt, 6);
    chk("R8 done and stopped", sts, 4'b0011);

    cur_req = "R7";
    do_clr(4'b1111);
    wr_desc(2, 1, 7);
    ready_mode = 2;
    hs_cnt = 0;
    do_start();
    wait_state("R7", 0, 100);
    chk("R7 valid dropped", tx_valid, 0);
    chk("R7 jabber+stopped", sts, 4'b1010);
    rd_desc(2);
    chk("R7 d2 own", sw_rown, 0);
    chk("R7 d2 jab mark", sw_rjab, 1);
    chk("R7 d2 done mark", sw_rdone, 0);
    ready_mode = 0;
    do_start();
    wait_state("R7", 3, 20);
    chk("R7 pointer stayed", hs_cnt, 0);

    tick(3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule